// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Ready-to-Send Flow Control

This block receives asynchronous serial characters on a single line and hands each one to a host through a parallel buffer. A programmable divider produces a 16x oversampling tick. A falling edge on the line arms the receiver, and a low level at the middle of the start bit confirms it. Each data bit is then sampled at its centre and shifted in from the top of a right-shifting register. When the selected number of bits has been shifted in, the character moves to the buffer, already right-justified. At the same moment a completion flag is set and, in interrupt mode, a one-cycle request pulse is raised.

The ready-to-send output (active low) is driven by receiver state alone. It drops when the receiver is switched on or when the host reads the buffer. It rises as soon as a new character is confirmed on the line. A sender that obeys this signal therefore never overruns the buffer, and no software handshake is needed. The block also flags a low stop bit and flags a character that completes while the previous one is still unread.

Top module: `uart_rts_rx`

## Requirements
- R1: After reset, `rts_n` is 1, `rx_done`, `rx_irq`, `rx_ferr` and `rx_ovr` are 0, `rx_data` is 0 and the receiver is idle.
- R2: A character is accepted only while `rx_en` is 1. It begins on a falling edge of `rxd` that is still low at the middle of the start bit. A low pulse shorter than half a bit is discarded, and any line activity while `rx_en` is 0 is ignored.
- R3: Bits arrive least significant first. `len_sel` 00 selects 7 data bits, 01 selects 8, and 10 or 11 select 9. `rx_data` holds the received bits in its low positions, and every unused upper bit reads 0.
- R4: `rx_done` rises on the same clock edge that loads `rx_data`. A one-cycle `rd_lo` clears it, unless a character completes in that same cycle.
- R5: `rx_irq` is a one-cycle pulse issued together with the rise of `rx_done`, and only when `irq_mode` is 0.
- R6: `rts_n` goes to 0 on the clock after `rx_en` changes from 0 to 1, and on the clock after any `rd_lo` pulse, whether the receiver is enabled or not.
- R7: `rts_n` goes to 1 on the clock after a start bit is confirmed. It then stays 1 until the next read or enable event.
- R8: The stop bit is sampled at its centre. If it is low, `rx_ferr` is set, and it stays set until `rd_lo`.
- R9: If a character completes while `rx_done` is still 1, `rx_ovr` is set and `rx_data` takes the new character. `rd_lo` clears `rx_ovr`.
- R10: The oversampling tick fires every `baud_div`+1 clocks, and one bit lasts 16 ticks. Dropping `rx_en` in the middle of a frame returns the receiver to idle without completing a character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| baud_div | input | DIV_W | Oversampling tick period minus one, in clocks |
| len_sel | input | 2 | Data length select (00: 7, 01: 8, 1x: 9 bits) |
| rx_en | input | 1 | Receiver enable |
| irq_mode | input | 1 | 0: pulse `rx_irq` on completion; 1: no pulse |
| rd_lo | input | 1 | One-cycle strobe: host reads the buffer's low byte |
| rxd | input | 1 | Serial input line, idle high |
| rx_data | output | MAX_BITS | Receive buffer, right-justified |
| rx_done | output | 1 | Receive-complete flag |
| rx_irq | output | 1 | Receive interrupt request pulse |
| rx_ferr | output | 1 | Framing-error flag |
| rx_ovr | output | 1 | Overrun flag |
| rts_n | output | 1 | Ready to send, active low |

## Verification
The hardest state to reach from the ports is a frame that was confirmed and then abandoned. In that state the flow-control output has already risen, the shift register holds partial data, and the oversampling divider is running. The stimulus sends a start bit and a few data bits, drops `rx_en` in mid-frame, and returns the line high before re-enabling. It then confirms three things: no completion appeared, the re-enable pulled `rts_n` low, and the next clean frame arrives intact. False starts, overrun with the buffer replaced, and a frame with a low stop bit are driven the same way by shaping the line directly.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

    localparam int OVS = 16;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    output logic rx_lvl,
    output logic rx_fall
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d      = q;
        d.s1   = rxd;
        d.s2   = q.s1;
        d.prev = q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{s1: 1'b1, s2: 1'b1, prev: 1'b1};
        else        q <= d;
    end

    assign rx_lvl  = q.s2;
    assign rx_fall = q.prev & ~q.s2;

endmodule

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q, cnt_d;

    always_comb begin
        tick = run && (cnt_q == div);
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import uart_rx_pkg::*;
#(
    parameter int MAX_BITS = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_en,
    input  logic                rx_lvl,
    input  logic                rx_fall,
    input  logic                tick,
    input  logic [1:0]          len_sel,
    output logic                busy,
    output logic                start_ok,
    output logic                char_done,
    output logic [MAX_BITS-1:0] char_data,
    output logic                stop_done,
    output logic                stop_bad
);
    localparam int SUB_W = $clog2(OVS);
    localparam int CNT_W = $clog2(MAX_BITS + 1);
    localparam logic [SUB_W-1:0] SUB_HALF = SUB_W'(OVS / 2 - 1);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

    typedef struct packed {
        rx_state_e           state;
        logic [SUB_W-1:0]    sub;
        logic [CNT_W-1:0]    bitn;
        logic [MAX_BITS-1:0] sh;
    } fsm_t;

    fsm_t q, d;
    logic [CNT_W-1:0]    nbits;
    logic [CNT_W-1:0]    shamt;
    logic [MAX_BITS-1:0] sh_nxt;

    function automatic logic [CNT_W-1:0] len_bits(input logic [1:0] code);
        case (code)
            2'b00:   return CNT_W'(MAX_BITS - 2);
            2'b01:   return CNT_W'(MAX_BITS - 1);
            default: return CNT_W'(MAX_BITS);
        endcase
    endfunction

    always_comb begin
        d         = q;
        start_ok  = 1'b0;
        char_done = 1'b0;
        stop_done = 1'b0;
        stop_bad  = 1'b0;
        nbits     = len_bits(len_sel);
        shamt     = CNT_W'(MAX_BITS) - nbits;
        sh_nxt    = {rx_lvl, q.sh[MAX_BITS-1:1]};
        char_data = sh_nxt >> shamt;

        case (q.state)
            RX_IDLE: begin
                d.sub = '0;
                if (rx_fall) d.state = RX_START;
            end
            RX_START: if (tick) begin
                if (q.sub == SUB_HALF) begin
                    d.sub = '0;
                    if (!rx_lvl) begin
                        d.state  = RX_DATA;
                        d.bitn   = '0;
                        start_ok = 1'b1;
                    end else begin
                        d.state = RX_IDLE;
                    end
                end else begin
                    d.sub = q.sub + SUB_W'(1);
                end
            end
            RX_DATA: if (tick) begin
                if (q.sub == SUB_LAST) begin
                    d.sub = '0;
                    d.sh  = sh_nxt;
                    if (q.bitn == nbits - CNT_W'(1)) begin
                        char_done = 1'b1;
                        d.bitn    = '0;
                        d.state   = RX_STOP;
                    end else begin
                        d.bitn = q.bitn + CNT_W'(1);
                    end
                end else begin
                    d.sub = q.sub + SUB_W'(1);
                end
            end
            RX_STOP: if (tick) begin
                if (q.sub == SUB_LAST) begin
                    d.sub     = '0;
                    stop_done = 1'b1;
                    stop_bad  = ~rx_lvl;
                    d.state   = RX_IDLE;
                end else begin
                    d.sub = q.sub + SUB_W'(1);
                end
            end
            default: d.state = RX_IDLE;
        endcase

        if (!rx_en) begin
            d.state   = RX_IDLE;
            d.sub     = '0;
            d.bitn    = '0;
            start_ok  = 1'b0;
            char_done = 1'b0;
            stop_done = 1'b0;
            stop_bad  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: RX_IDLE, sub: '0, bitn: '0, sh: '0};
        else        q <= d;
    end

    assign busy = (q.state != RX_IDLE);

endmodule

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl #(
    parameter int MAX_BITS = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_en,
    input  logic                irq_mode,
    input  logic                rd_lo,
    input  logic                start_ok,
    input  logic                char_done,
    input  logic [MAX_BITS-1:0] char_data,
    input  logic                stop_done,
    input  logic                stop_bad,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_done,
    output logic                rx_irq,
    output logic                rx_ferr,
    output logic                rx_ovr,
    output logic                rts_n
);
    typedef struct packed {
        logic                en;
        logic                rts_n;
        logic                done;
        logic                irq;
        logic                ferr;
        logic                ovr;
        logic [MAX_BITS-1:0] data;
    } ctrl_t;

    ctrl_t q, d;
    logic  en_rise;

    always_comb begin
        d       = q;
        en_rise = rx_en && !q.en;
        d.en    = rx_en;
        d.irq   = char_done && !irq_mode;

        if (char_done) begin
            d.data = char_data;
            d.done = 1'b1;
        end else if (rd_lo) begin
            d.done = 1'b0;
        end

        if (char_done && q.done && !rd_lo) d.ovr = 1'b1;
        else if (rd_lo)                    d.ovr = 1'b0;

        if (stop_done && stop_bad) d.ferr = 1'b1;
        else if (rd_lo)            d.ferr = 1'b0;

        if (start_ok)                d.rts_n = 1'b1;
        else if (rd_lo || en_rise)   d.rts_n = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{en: 1'b0, rts_n: 1'b1, done: 1'b0, irq: 1'b0,
                           ferr: 1'b0, ovr: 1'b0, data: '0};
        else        q <= d;
    end

    assign rx_data = q.data;
    assign rx_done = q.done;
    assign rx_irq  = q.irq;
    assign rx_ferr = q.ferr;
    assign rx_ovr  = q.ovr;
    assign rts_n   = q.rts_n;

endmodule

// File: rtl/uart_rts_rx.sv
module uart_rts_rx #(
    parameter int DIV_W    = 8,
    parameter int MAX_BITS = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DIV_W-1:0]    baud_div,
    input  logic [1:0]          len_sel,
    input  logic                rx_en,
    input  logic                irq_mode,
    input  logic                rd_lo,
    input  logic                rxd,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_done,
    output logic                rx_irq,
    output logic                rx_ferr,
    output logic                rx_ovr,
    output logic                rts_n
);
    logic                rx_lvl, rx_fall, tick, busy;
    logic                start_ok, char_done, stop_done, stop_bad;
    logic [MAX_BITS-1:0] char_data;

    uart_rx_sync i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rxd     (rxd),
        .rx_lvl  (rx_lvl),
        .rx_fall (rx_fall)
    );

    uart_rx_tick #(.DIV_W(DIV_W)) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .div   (baud_div),
        .tick  (tick)
    );

    uart_rx_fsm #(.MAX_BITS(MAX_BITS)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .rx_lvl    (rx_lvl),
        .rx_fall   (rx_fall),
        .tick      (tick),
        .len_sel   (len_sel),
        .busy      (busy),
        .start_ok  (start_ok),
        .char_done (char_done),
        .char_data (char_data),
        .stop_done (stop_done),
        .stop_bad  (stop_bad)
    );

    uart_rx_ctrl #(.MAX_BITS(MAX_BITS)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .irq_mode  (irq_mode),
        .rd_lo     (rd_lo),
        .start_ok  (start_ok),
        .char_done (char_done),
        .char_data (char_data),
        .stop_done (stop_done),
        .stop_bad  (stop_bad),
        .rx_data   (rx_data),
        .rx_done   (rx_done),
        .rx_irq    (rx_irq),
        .rx_ferr   (rx_ferr),
        .rx_ovr    (rx_ovr),
        .rts_n     (rts_n)
    );

endmodule

// File: rtl/uart_rts_rx_chk.sv
module uart_rts_rx_chk #(
    parameter int MAX_BITS = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rx_en,
    input logic                irq_mode,
    input logic                rd_lo,
    input logic [1:0]          len_sel,
    input logic [MAX_BITS-1:0] rx_data,
    input logic                rx_done,
    input logic                rx_irq,
    input logic                rx_ovr,
    input logic                rts_n,
    input logic                start_ok,
    input logic                char_done,
    input logic                busy
);
    p_idle_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !busy);

    p_rts_up_on_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> rts_n);

    p_rts_down_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && !start_ok) |=> !rts_n);

    p_done_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        char_done |=> rx_done);

    p_done_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && !char_done) |=> !rx_done);

    p_irq_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (rx_done && !$past(irq_mode)));

    p_irq_issued_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && !irq_mode) |=> rx_irq);

    p_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && rx_done && !rd_lo) |=> rx_ovr);

    p_len7_zero_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && len_sel == 2'b00) |=> (rx_data[MAX_BITS-1:MAX_BITS-2] == 2'b00));

endmodule

bind uart_rts_rx uart_rts_rx_chk #(.MAX_BITS(MAX_BITS)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .irq_mode  (irq_mode),
    .rd_lo     (rd_lo),
    .len_sel   (len_sel),
    .rx_data   (rx_data),
    .rx_done   (rx_done),
    .rx_irq    (rx_irq),
    .rx_ovr    (rx_ovr),
    .rts_n     (rts_n),
    .start_ok  (start_ok),
    .char_done (char_done),
    .busy      (busy)
);

// File: tb/test_uart_rts_rx.sv
module test_uart_rts_rx;
    localparam int DIV_W    = 8;
    localparam int MAX_BITS = 9;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [DIV_W-1:0]    baud_div = 8'd3;
    logic [1:0]          len_sel = 2'b01;
    logic                rx_en = 1'b0;
    logic                irq_mode = 1'b0;
    logic                rd_lo = 1'b0;
    logic                rxd = 1'b1;
    logic [MAX_BITS-1:0] rx_data;
    logic                rx_done, rx_irq, rx_ferr, rx_ovr, rts_n;

    int n_chk = 0;
    int n_fail = 0;
    int irq_seen = 0;
    int irq_exp = 0;
    int bit_clks = 64;

    always #2 clk = ~clk;

    uart_rts_rx #(.DIV_W(DIV_W), .MAX_BITS(MAX_BITS)) i_uart_rts_rx (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .len_sel(len_sel),
        .rx_en(rx_en), .irq_mode(irq_mode), .rd_lo(rd_lo), .rxd(rxd),
        .rx_data(rx_data), .rx_done(rx_done), .rx_irq(rx_irq),
        .rx_ferr(rx_ferr), .rx_ovr(rx_ovr), .rts_n(rts_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock reference: an interrupt pulse must coincide with a set flag in interrupt mode
    always @(negedge clk) begin
        if (rst_n && rx_irq) begin
            irq_seen++;
            chk("R5 irq with done", int'(rx_done), 1);
            chk("R5 irq only in mode 0", int'(irq_mode), 0);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input int val, input int nb, input bit stop, input bit rts_mid);
        rxd = 1'b0;
        idle(bit_clks);
        for (int i = 0; i < nb; i++) begin
            rxd = val[i];
            if (i == 1) begin
                idle(bit_clks / 2);
                if (rts_mid) chk("R7 rts high during frame", int'(rts_n), 1);
                idle(bit_clks - bit_clks / 2);
            end else begin
                idle(bit_clks);
            end
        end
        rxd = stop;
        idle(bit_clks);
        rxd = 1'b1;
        idle(4);
    endtask

    task automatic host_read();
        rd_lo = 1'b1;
        idle(1);
        rd_lo = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        chk("R1 rts_n", int'(rts_n), 1);
        chk("R1 done", int'(rx_done), 0);
        chk("R1 ferr", int'(rx_ferr), 0);
        chk("R1 ovr", int'(rx_ovr), 0);
        chk("R1 irq", int'(rx_irq), 0);
        chk("R1 data", int'(rx_data), 0);

        // R2 disabled receiver ignores the line
        send(8'hA5, 8, 1'b1, 1'b0);
        chk("R2 disabled no done", int'(rx_done), 0);
        chk("R2 disabled rts", int'(rts_n), 1);

        // R6 enable pulls rts low
        rx_en = 1'b1;
        idle(1);
        chk("R6 rts low on enable", int'(rts_n), 0);

        // R3/R4/R5/R7 eight-bit character
        send(8'hA5, 8, 1'b1, 1'b1);
        irq_exp++;
        chk("R3 data 8 bit", int'(rx_data), 'hA5);
        chk("R4 done set", int'(rx_done), 1);
        chk("R5 irq count", irq_seen, irq_exp);
        chk("R7 rts held until read", int'(rts_n), 1);
        chk("R8 ferr clear on good stop", int'(rx_ferr), 0);
        host_read();
        chk("R4 done cleared by read", int'(rx_done), 0);
        chk("R6 rts low after read", int'(rts_n), 0);

        // R2 short glitch is discarded
        rxd = 1'b0;
        idle(5);
        rxd = 1'b1;
        idle(3 * bit_clks);
        chk("R2 glitch no start rts", int'(rts_n), 0);
        chk("R2 glitch no done", int'(rx_done), 0);

        // R3 seven-bit length
        len_sel = 2'b00;
        send('h1D3, 7, 1'b1, 1'b1);
        irq_exp++;
        chk("R3 data 7 bit", int'(rx_data), 'h53);
        host_read();

        // R3 nine-bit length
        len_sel = 2'b10;
        send('h1A6, 9, 1'b1, 1'b1);
        irq_exp++;
        chk("R3 data 9 bit", int'(rx_data), 'h1A6);
        host_read();
        len_sel = 2'b01;

        // R5 no pulse in polled mode
        irq_mode = 1'b1;
        send('h3C, 8, 1'b1, 1'b1);
        chk("R5 no irq when mode 1", irq_seen, irq_exp);
        chk("R4 done in mode 1", int'(rx_done), 1);
        host_read();
        irq_mode = 1'b0;

        // R8 low stop bit
        send('h81, 8, 1'b0, 1'b1);
        irq_exp++;
        chk("R8 ferr set", int'(rx_ferr), 1);
        chk("R8 data kept", int'(rx_data), 'h81);
        host_read();
        chk("R8 ferr cleared", int'(rx_ferr), 0);

        // R9 overrun replaces buffer
        send('h11, 8, 1'b1, 1'b1);
        send('h22, 8, 1'b1, 1'b1);
        irq_exp += 2;
        chk("R9 ovr set", int'(rx_ovr), 1);
        chk("R9 data replaced", int'(rx_data), 'h22);
        host_read();
        chk("R9 ovr cleared", int'(rx_ovr), 0);
        chk("R9 done cleared", int'(rx_done), 0);

        // R10 abort mid-frame
        rxd = 1'b0;
        idle(bit_clks);
        rxd = 1'b1;
        idle(3 * bit_clks);
        chk("R7 rts up on aborted start", int'(rts_n), 1);
        rx_en = 1'b0;
        idle(4);
        rx_en = 1'b1;
        idle(1);
        chk("R6 rts low on re-enable", int'(rts_n), 0);
        idle(12 * bit_clks);
        chk("R10 abort no done", int'(rx_done), 0);
        send('h5A, 8, 1'b1, 1'b1);
        irq_exp++;
        chk("R10 clean frame after abort", int'(rx_data), 'h5A);
        host_read();

        // R10 other divider
        baud_div = 8'd1;
        bit_clks = 32;
        send('hC3, 8, 1'b1, 1'b1);
        irq_exp++;
        chk("R10 data at div 1", int'(rx_data), 'hC3);
        chk("R5 irq total", irq_seen, irq_exp);
        host_read();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule